// File: doc/BRIEF.md
# Activity-Kicked Watchdog Reset Generator

This block watches a serial data line driven by a host processor and treats each low-to-high transition on it as a sign that the host is alive. Each such rising edge restarts a long timeout. If the timeout runs out with no rising edge, the block drives an active-high reset pulse of fixed width. It then releases the reset and starts timing again from zero, with no edge needed.

The monitored line is asynchronous to the block's clock. It passes through a two-flop synchronizer before a rising-edge detector. The timeout and pulse lengths are given in microseconds together with the clock frequency, and are turned into cycle counts when the block is built. The defaults are 4.75 s of silence and a 460 µs pulse at 100 MHz. An asynchronous active-low power-on reset clears all state.

Top module: `act_wdog_rstgen`

## Requirements
- R1: While `rst_n` is low, `rst_out` is 0 and the timeout count is cleared. With no activity, `rst_out` first goes high on the TIMEOUT_CYCLES-th rising clock edge after `rst_n` is released.
- R2: Only a low-to-high transition on `line_in` restarts the timeout. A falling transition, a steady high level and a steady low level do not. A rising transition that is set up before clock edge a is applied at edge a+2, which counts as the new start point.
- R3: When no restart happens, `rst_out` goes high exactly TIMEOUT_CYCLES clock edges after the last start point.
- R4: Each reset pulse keeps `rst_out` high for exactly PULSE_CYCLES clock cycles and then returns it to 0.
- R5: The edge on which `rst_out` returns to 0 is a new start point, with no edge on `line_in` needed. With a silent line, pulses therefore repeat every TIMEOUT_CYCLES + PULSE_CYCLES cycles.
- R6: Rising transitions on `line_in` that are applied while the pulse is active have no effect. The next pulse comes TIMEOUT_CYCLES edges after the pulse ends.
- R7: A restart applied on the same edge at which the timeout would expire wins, and no pulse starts on that edge.
- R8: Pulling `rst_n` low during a pulse drives `rst_out` to 0 at once, without waiting for a clock edge.
- R9: TIMEOUT_CYCLES = CLK_HZ·TIMEOUT_US/10^6 and PULSE_CYCLES = CLK_HZ·PULSE_US/10^6, each at least 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| line_in | input | 1 | Monitored serial data line, asynchronous |
| rst_out | output | 1 | Active-high reset pulse produced on timeout |

## Verification
A rising transition on `line_in` set up before edge a becomes a start point at edge a+2: two edges go to the synchronizer and the third applies the restart. `rst_out` is registered, so it is due high exactly TIMEOUT_CYCLES edges after a start point and low again PULSE_CYCLES edges later. The bench numbers the edges from reset release, changes inputs only at falling clock edges, and compares `rst_out` after every edge with a value computed from these offsets. It does this for a kick placed at each edge of the timeout window, including the edge that collides with expiry.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Converts a duration in microseconds to a whole number of clock cycles (minimum 1).
  function automatic int us_to_cycles(longint clk_hz, longint dur_us);
    longint c;
    c = (clk_hz * dur_us) / 64'd1000000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

  // Width of a counter that must hold the values 0 .. n-1.
  function automatic int cnt_width(int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/wdog_sync_edge.sv
module wdog_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic rise
);
  // [0],[1]: synchronizer flops, [2]: previous synchronized value
  logic [2:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[1:0], d_async};
  end

  assign rise = shreg[1] & ~shreg[2];

  // R2: a detected rise lasts one cycle only
  p_single_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int LIMIT = 16,
  parameter int W     = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic         kick,
  output logic         expire,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  assign expire = !hold && !kick && (count == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      count <= '0;
    else if (hold || kick || expire) count <= '0;
    else                             count <= count + 1'b1;
  end

  // R3: the count never runs past its limit
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= LAST);
  // R2: an accepted kick restarts the count from zero
  p_kick_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && !hold) |=> (count == '0));

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int WIDTH = 4,
  parameter int W     = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  output logic         active,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] LAST = W'(WIDTH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      count  <= '0;
    end else if (active) begin
      if (count == LAST) begin
        active <= 1'b0;
        count  <= '0;
      end else begin
        count <= count + 1'b1;
      end
    end else if (start) begin
      active <= 1'b1;
      count  <= '0;
    end
  end

  // R4: the pulse counter stays inside the pulse width
  p_width_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (count <= LAST));
  // R4: the pulse ends only once its full width has elapsed
  p_full_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> ($past(count) == LAST));

endmodule

// File: rtl/act_wdog_rstgen.sv
module act_wdog_rstgen #(
  parameter longint CLK_HZ     = 100000000,
  parameter longint TIMEOUT_US = 4750000,
  parameter longint PULSE_US   = 460
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic rst_out
);
  import wdog_pkg::*;

  // R9: cycle counts derived from frequency and durations
  localparam int TIMEOUT_CYCLES = us_to_cycles(CLK_HZ, TIMEOUT_US);
  localparam int PULSE_CYCLES   = us_to_cycles(CLK_HZ, PULSE_US);
  localparam int TW             = cnt_width(TIMEOUT_CYCLES);
  localparam int PW             = cnt_width(PULSE_CYCLES);

  logic          line_rise;
  logic          tmr_expire;
  logic [TW-1:0] tmr_count;
  logic [PW-1:0] pls_count;
  logic          pulse_on;

  wdog_sync_edge u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (line_in),
    .rise    (line_rise)
  );

  // R6: the timer is held cleared while the pulse is active
  wdog_timer #(.LIMIT(TIMEOUT_CYCLES), .W(TW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold   (pulse_on),
    .kick   (line_rise),
    .expire (tmr_expire),
    .count  (tmr_count)
  );

  wdog_pulse #(.WIDTH(PULSE_CYCLES), .W(PW)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (tmr_expire),
    .active (pulse_on),
    .count  (pls_count)
  );

  assign rst_out = pulse_on;

  // R1: output low throughout power-on reset
  p_por_low_r1: assert property (@(posedge clk) !rst_n |-> !rst_out);
  // R3: an expiry raises the reset output on the next edge
  p_expire_fires_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_expire |=> rst_out);
  // R6: no timing progresses while the pulse is active
  p_ignore_during_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out |-> (tmr_count == '0));
  // R5: timing restarts from zero when the pulse ends
  p_rearm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out) |-> (tmr_count == '0));

endmodule

// File: tb/tb_act_wdog_rstgen.sv
module tb_act_wdog_rstgen;
  // small configuration: 1 MHz nominal, 20 us timeout, 5 us pulse
  localparam int T = 20;
  localparam int P = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_in = 1'b0;
  logic rst_out;

  int checks = 0;
  int errors = 0;
  int k = 0;   // clock edges since reset release

  always #5 clk = ~clk;

  act_wdog_rstgen #(.CLK_HZ(1000000), .TIMEOUT_US(T), .PULSE_US(P)) dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .rst_out(rst_out)
  );

  task automatic check(input bit got, input bit exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s at edge %0d: rst_out=%0b expected %0b", req, k, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    k++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    line_in = 1'b0;
    repeat (3) @(negedge clk);
    check(rst_out, 1'b0, "R1 reset state");
    rst_n = 1'b1;
    k = 0;
  endtask

  // expected output on a silent line, k edges after release
  function automatic bit idle_exp(int kk);
    return (kk >= T) && ((kk % (T + P)) >= T);
  endfunction

  task automatic run_done();
    // R1 R3 R4 R5: silent line
    do_reset();
    for (int i = 0; i < 2 * (T + P) + 3; i++) begin
      step();
      check(rst_out, idle_exp(k), "R1/R3/R4/R5 silent line");
    end

    // R2 R7: one kick at every position of the window; falling edge follows
    for (int d = 1; d <= T - 3; d++) begin
      do_reset();
      repeat (d) step();
      line_in = 1'b1;
      step();
      step();
      line_in = 1'b0;
      while (k < d + 3 + T + 2) begin
        step();
        check(rst_out, (k >= d + 3 + T) && (k < d + 3 + T + P),
              (d == T - 3) ? "R7 kick on expiry edge" : "R2 kick restart");
      end
    end

    // R2: line held high after its rise gives a single restart
    do_reset();
    repeat (4) step();
    line_in = 1'b1;
    while (k < 4 + 3 + T + P + 1) begin
      step();
      check(rst_out, (k >= 7 + T) && (k < 7 + T + P), "R2 steady high");
    end

    // R6: rising edge during the pulse is ignored
    do_reset();
    while (k < T + 1) step();
    line_in = 1'b1;
    step();
    step();
    line_in = 1'b0;
    while (k < 2 * T + P + 2) begin
      step();
      check(rst_out, idle_exp(k), "R6 edge during pulse");
    end

    // R8: asynchronous reset during the pulse
    do_reset();
    while (k < T + 2) step();
    check(rst_out, 1'b1, "R8 pulse active before reset");
    #1 rst_n = 1'b0;
    #1 check(rst_out, 1'b0, "R8 async clear");
    rst_n = 1'b1;
  endtask

  initial begin
    fork
      begin
        run_done();
      end
      begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule